// File: doc/BRIEF.md
# Alarm-Driven Converter Clear Controller

This block decides, for each of NUM_CH converter channels, whether that channel is held in its clear (zero-code) state. A channel can be cleared in two ways. Software can clear it directly with a per-channel clear bit. An alarm can also clear it. Alarm events come from NUM_EVT internal event lines and from one asynchronous hardware alarm pin. Each event latches a sticky status bit. That bit stays set until the host acknowledges it by writing a one to it.

The host sets up two masks. The source mask chooses which status bits are allowed to clear channels. The channel-enable mask chooses which channels obey those alarm-caused clears. An alarm-caused clear lasts while any status bit that is both set and source-enabled remains. It ends one cycle after the last such bit is acknowledged. The clear vector is registered and feeds the converter register bank.

Top module: `alarm_clear_ctrl`

## Requirements
- R1: During and after reset, the status bits, both masks, the software clear bits and `dac_clear` are all zero.
- R2: Software clear bit c set means `dac_clear[c]` is 1 from the next cycle, whatever the masks and status hold.
- R3: An event line `alarm_evt[i]` high at a clock edge makes `alarm_status[i]` 1 after that edge.
- R4: A set status bit stays set until a status write (select 3) carries a one in that bit position. Writes with a zero there, and writes to other selects, leave it set.
- R5: When a status write and a new event for the same bit fall on the same edge, the bit stays set.
- R6: The hardware pin `alarm_hw` is active high and passes through two synchronising flops. It sets status bit NUM_EVT (the top bit) three edges after it is first sampled.
- R7: A set status bit whose source-mask bit is 0 causes no channel to be cleared.
- R8: Alarm-caused clears reach only channels whose channel-enable bit is 1.
- R9: A channel not under software clear leaves clear one cycle after no status bit remains that is both set and source-enabled. While any such bit remains, an enabled channel stays cleared.
- R10: `dac_clear` is a register. Its value after an edge is software clear OR (channel-enable AND any set, source-enabled status bit), all taken from the state just before that edge.
- R11: When `host_we` is high, `host_sel` picks the target, with `host_wdata` aligned to bit 0. The select codes are 0 for software clear, 1 for channel-enable, 2 for source mask and 3 for status acknowledge (write one to clear). Each write takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_evt | input | NUM_EVT | Synchronous alarm event lines, one per status bit |
| alarm_hw | input | 1 | Asynchronous hardware alarm pin, active high |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Write target select (0 swclr, 1 chen, 2 srcen, 3 status ack) |
| host_wdata | input | WD_W | Write data, bit 0 aligned |
| dac_clear | output | NUM_CH | Registered per-channel clear vector |
| alarm_status | output | NUM_EVT+1 | Sticky alarm status, hardware pin in top bit |

## Verification
Different inputs take different numbers of edges to show up at the outputs. An event line or a status acknowledge changes `alarm_status` one edge later, and `dac_clear` one edge after that. A mask or software-clear write changes `dac_clear` two edges after the write is presented. The hardware pin reaches status after three edges and the clear vector after four. The bench drives inputs on the falling edge. It advances a reference state on every rising edge and compares both outputs at the next falling edge, so every latency is checked on its exact cycle. Directed checks count these edges explicitly for the hand-worked corner cases.

// File: rtl/alarm_clear_pkg.sv
package alarm_clear_pkg;

   typedef enum logic [1:0] {
      SEL_SWCLR  = 2'd0,
      SEL_CHEN   = 2'd1,
      SEL_SRCEN  = 2'd2,
      SEL_STATUS = 2'd3
   } host_sel_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/alm_sync.sv
module alm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("alm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

   // R6: a sampled high reaches the second flop one edge later
   p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_q[0] |=> sh_q[1]);

endmodule

// File: rtl/alm_status.sv
module alm_status #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic            ack_en,
   input  logic [NSRC-1:0] ack_mask,
   output logic [NSRC-1:0] status
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("alm_status: NSRC must be at least 1");
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic st_q;
      logic ack_hit;
      assign ack_hit = ack_en & ack_mask[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= 1'b0;
         else        st_q <= (st_q & ~ack_hit) | evt[i];
      end

      assign status[i] = st_q;

      // R3 / R5: an event always lands, even against an acknowledge
      p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> status[i]);
      // R4: sticky until acknowledged
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !(ack_en && ack_mask[i])) |=> status[i]);
      p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_en && ack_mask[i] && !evt[i]) |=> !status[i]);
   end

endmodule

// File: rtl/clr_cfg_regs.sv
module clr_cfg_regs
   import alarm_clear_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int NSRC   = 8,
   parameter int WD_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic [WD_W-1:0]   host_wdata,
   output logic [NUM_CH-1:0] sw_clr,
   output logic [NUM_CH-1:0] ch_en,
   output logic [NSRC-1:0]   src_en,
   output logic              ack_en,
   output logic [NSRC-1:0]   ack_mask
);
   if (WD_W < NUM_CH || WD_W < NSRC) begin : g_bad_wd
      $error("clr_cfg_regs: WD_W narrower than a target register");
   end

   logic wr_sw, wr_ch, wr_src;
   assign wr_sw  = host_we && (host_sel == SEL_SWCLR);
   assign wr_ch  = host_we && (host_sel == SEL_CHEN);
   assign wr_src = host_we && (host_sel == SEL_SRCEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sw_clr <= '0;
      else if (wr_sw) sw_clr <= host_wdata[NUM_CH-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ch_en <= '0;
      else if (wr_ch) ch_en <= host_wdata[NUM_CH-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_en <= '0;
      else if (wr_src) src_en <= host_wdata[NSRC-1:0];
   end

   assign ack_en   = host_we && (host_sel == SEL_STATUS);
   assign ack_mask = host_wdata[NSRC-1:0];

   // R11: registers only move on a matching write
   p_sw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_sel == SEL_SWCLR) |=> $stable(sw_clr));
   p_ch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_sel == SEL_CHEN) |=> $stable(ch_en));
   p_src_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_sel == SEL_SRCEN) |=> $stable(src_en));

endmodule

// File: rtl/clr_combine.sv
module clr_combine #(
   parameter int NUM_CH = 16,
   parameter int NSRC   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   status,
   input  logic [NSRC-1:0]   src_en,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] sw_clr,
   output logic [NUM_CH-1:0] clr_q
);
   logic alarm_hit;
   assign alarm_hit = |(status & src_en);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clr_q[c] <= 1'b0;
         else        clr_q[c] <= sw_clr[c] | (ch_en[c] & alarm_hit);
      end

      // R2: software clear always wins
      p_sw_r2: assert property (@(posedge clk) disable iff (!rst_n)
         sw_clr[c] |=> clr_q[c]);
      // R8: disabled channel ignores alarms
      p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_en[c] && !sw_clr[c]) |=> !clr_q[c]);
      // R7 / R9: no qualifying status bit -> released
      p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!sw_clr[c] && ((status & src_en) == '0)) |=> !clr_q[c]);
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_en[c] && ((status & src_en) != '0)) |=> clr_q[c]);
   end

endmodule

// File: rtl/alarm_clear_ctrl.sv
module alarm_clear_ctrl
   import alarm_clear_pkg::*;
#(
   parameter  int NUM_CH      = 16,
   parameter  int NUM_EVT     = 7,
   parameter  int SYNC_STAGES = 2,
   localparam int NSRC        = NUM_EVT + 1,
   localparam int WD_W        = (NUM_CH > NSRC) ? NUM_CH : NSRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EVT-1:0] alarm_evt,
   input  logic              alarm_hw,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic [WD_W-1:0]   host_wdata,
   output logic [NUM_CH-1:0] dac_clear,
   output logic [NSRC-1:0]   alarm_status
);
   if (NUM_CH < 1 || NUM_EVT < 1) begin : g_bad_top
      $error("alarm_clear_ctrl: NUM_CH and NUM_EVT must be at least 1");
   end
   if (WD_W != max_i(NUM_CH, NSRC)) begin : g_bad_wd
      $error("alarm_clear_ctrl: write width mismatch");
   end

   logic              hw_sync;
   logic [NSRC-1:0]   evt_all;
   logic [NUM_CH-1:0] sw_clr, ch_en;
   logic [NSRC-1:0]   src_en, ack_mask;
   logic              ack_en;

   alm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(alarm_hw), .q(hw_sync));

   assign evt_all = {hw_sync, alarm_evt};

   clr_cfg_regs #(.NUM_CH(NUM_CH), .NSRC(NSRC), .WD_W(WD_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .sw_clr(sw_clr), .ch_en(ch_en),
      .src_en(src_en), .ack_en(ack_en), .ack_mask(ack_mask));

   alm_status #(.NSRC(NSRC)) u_status (
      .clk(clk), .rst_n(rst_n), .evt(evt_all), .ack_en(ack_en),
      .ack_mask(ack_mask), .status(alarm_status));

   clr_combine #(.NUM_CH(NUM_CH), .NSRC(NSRC)) u_comb (
      .clk(clk), .rst_n(rst_n), .status(alarm_status), .src_en(src_en),
      .ch_en(ch_en), .sw_clr(sw_clr), .clr_q(dac_clear));

   // R1: outputs are zero while reset is held
   always_comb begin
      if (!rst_n) begin
         a_reset_r1: assert (dac_clear == '0 && alarm_status == '0);
      end
   end

endmodule

// File: tb/alarm_clear_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_clear_ctrl_tb;
   localparam int NUM_CH  = 16;
   localparam int NUM_EVT = 7;
   localparam int NSRC    = NUM_EVT + 1;
   localparam int WD_W    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_EVT-1:0] alarm_evt = '0;
   logic alarm_hw = 1'b0;
   logic host_we = 1'b0;
   logic [1:0] host_sel = '0;
   logic [WD_W-1:0] host_wdata = '0;
   logic [NUM_CH-1:0] dac_clear;
   logic [NSRC-1:0] alarm_status;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [NUM_CH-1:0] m_sw = '0, m_en = '0, m_clr = '0;
   logic [NSRC-1:0]   m_src = '0, m_st = '0;
   logic m_s1 = 1'b0, m_s2 = 1'b0;

   always #2.5 clk = ~clk;

   alarm_clear_ctrl #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT)) u_dut (
      .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .alarm_hw(alarm_hw),
      .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
      .dac_clear(dac_clear), .alarm_status(alarm_status));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [NUM_CH-1:0] exp_clr(
      input logic [NUM_CH-1:0] sw, input logic [NUM_CH-1:0] en,
      input logic [NSRC-1:0] st, input logic [NSRC-1:0] src);
      return sw | ((|(st & src)) ? en : '0);
   endfunction

   task automatic step(input string tag);
      logic [NSRC-1:0] ack;
      @(posedge clk);
      ack = (host_we && host_sel == 2'd3) ? host_wdata[NSRC-1:0] : '0;
      m_clr = exp_clr(m_sw, m_en, m_st, m_src);
      m_st  = (m_st & ~ack) | {m_s2, alarm_evt};
      m_s2  = m_s1;
      m_s1  = alarm_hw;
      if (host_we && host_sel == 2'd0) m_sw  = host_wdata[NUM_CH-1:0];
      if (host_we && host_sel == 2'd1) m_en  = host_wdata[NUM_CH-1:0];
      if (host_we && host_sel == 2'd2) m_src = host_wdata[NSRC-1:0];
      @(negedge clk);
      chk({tag, " dac_clear"}, 32'(dac_clear), 32'(m_clr));
      chk({tag, " status"}, 32'(alarm_status), 32'(m_st));
   endtask

   task automatic wr(input string tag, input logic [1:0] sel, input logic [WD_W-1:0] d);
      host_we = 1'b1; host_sel = sel; host_wdata = d;
      step(tag);
      host_we = 1'b0; host_wdata = '0;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #12;
      chk("R1 reset clear", 32'(dac_clear), 32'h0);
      chk("R1 reset status", 32'(alarm_status), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      step("R1");
      chk("R1 after release", 32'(dac_clear), 32'h0);

      // R2 / R11: software clear via select 0, two edges to output
      wr("R2", 2'd0, 16'h0005);
      chk("R2 not yet", 32'(dac_clear), 32'h0);
      step("R2");
      chk("R2 sw clear", 32'(dac_clear), 32'h0005);
      wr("R2", 2'd0, 16'h0000);
      step("R2");
      chk("R2 released", 32'(dac_clear), 32'h0);

      // R8 / R11: enables and sources
      wr("R11", 2'd1, 16'h00F0);
      wr("R11", 2'd2, 16'h0001);
      alarm_evt = 7'h01;
      step("R3");
      alarm_evt = '0;
      chk("R3 status set", 32'(alarm_status), 32'h01);
      step("R8");
      chk("R8 enabled channels", 32'(dac_clear), 32'h00F0);

      // R4: stickiness, zero-write and other-select writes
      step("R4"); step("R4");
      wr("R4", 2'd3, 16'h0000);
      wr("R4", 2'd0, 16'h0000);
      chk("R4 still set", 32'(alarm_status), 32'h01);

      // R5: event against acknowledge
      alarm_evt = 7'h01;
      wr("R5", 2'd3, 16'h0001);
      alarm_evt = '0;
      chk("R5 event wins", 32'(alarm_status), 32'h01);

      // R9: acknowledge releases
      wr("R9", 2'd3, 16'h0001);
      chk("R9 status cleared", 32'(alarm_status), 32'h0);
      chk("R9 still held", 32'(dac_clear), 32'h00F0);
      step("R9");
      chk("R9 released", 32'(dac_clear), 32'h0);

      // R7: unmasked source ignored
      alarm_evt = 7'h02;
      step("R7");
      alarm_evt = '0;
      step("R7"); step("R7");
      chk("R7 no clear", 32'(dac_clear), 32'h0);
      chk("R7 status latched", 32'(alarm_status), 32'h02);

      // R9: two qualifying bits
      wr("R9", 2'd2, 16'h0003);
      alarm_evt = 7'h01;
      step("R9");
      alarm_evt = '0;
      step("R9");
      wr("R9", 2'd3, 16'h0001);
      step("R9");
      chk("R9 one left holds", 32'(dac_clear), 32'h00F0);
      wr("R9", 2'd3, 16'h0002);
      step("R9");
      chk("R9 all gone", 32'(dac_clear), 32'h0);

      // R6: hardware pin through synchroniser
      wr("R6", 2'd2, 16'h0080);
      alarm_hw = 1'b1;
      step("R6");
      alarm_hw = 1'b0;
      step("R6");
      chk("R6 not before third edge", 32'(alarm_status), 32'h0);
      step("R6");
      chk("R6 hw status", 32'(alarm_status), 32'h80);
      step("R6");
      chk("R6 hw clear", 32'(dac_clear), 32'h00F0);
      wr("R6", 2'd3, 16'h0080);

      // R10: random traffic against reference
      for (int n = 0; n < 3000; n++) begin
         logic [NUM_EVT-1:0] e;
         e = '0;
         for (int b = 0; b < NUM_EVT; b++) e[b] = (($urandom % 24) == 0);
         alarm_evt  = e;
         alarm_hw   = (($urandom % 10) == 0);
         host_we    = (($urandom % 3) == 0);
         host_sel   = 2'($urandom);
         host_wdata = WD_W'($urandom);
         step("R10");
      end
      alarm_evt = '0; alarm_hw = 1'b0; host_we = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule